// File: doc/BRIEF.md
# Dual-Channel Converter Serial Read Port

This block is the device side of the serial read port of a two-channel converter that samples both channels at once. A falling edge on the active-low start input begins a conversion. A counter in the system clock domain stands in for the converter's internal oscillator and sets how long the busy flag stays high. Both channel values are sampled from behavioural inputs in the same cycle as the start edge. They become the readable results when busy drops.

A host reads the results with an active-low select and a serial clock. Both inputs are asynchronous. They pass through a synchroniser, and their edges are detected in the system clock domain. While select is low, each data pin drives its own channel's 12-bit result MSB first. Each counted falling edge of the serial clock moves the pins on by one bit. If the host keeps select low past the twelfth counted edge, each pin goes on to send the other channel's result. A host can therefore read both results on a single wire.

The pins are modelled as a data bit and an output enable, to be joined at a pad cell. While a pin is not enabled, its data bit is held at zero.

Top module: `dual_adc_sport`

## Requirements
- R1: After reset, busy is low, both output enables are low, both data bits are 0 and both stored results are zero.
- R2: A start falling edge seen while busy is low raises busy. Busy stays high for exactly CONV_CYCLES system clock cycles and then falls.
- R3: A start falling edge that arrives while busy is high is ignored: busy still falls at the time set by the first edge.
- R4: Both channel inputs are sampled in the cycle the accepted start edge is detected. Later changes to the inputs do not alter the results that are published when busy falls.
- R5: While select is low, both output enables are high. Before any counted clock edge, pin A shows bit 11 of result A and pin B shows bit 11 of result B.
- R6: After k counted serial clock falling edges (1 ≤ k ≤ 11), pin A shows bit 11−k of result A and pin B shows bit 11−k of result B.
- R7: After k counted edges (12 ≤ k ≤ 23), pin A shows bit 23−k of result B and pin B shows bit 23−k of result A.
- R8: After 24 or more counted edges with select still low, both data bits stay at 0 until select rises.
- R9: Select going high drives both output enables low and both data bits to 0. The next frame starts again from bit 11.
- R10: A serial clock falling edge that is synchronised in the same cycle as the select falling edge is not counted.
- R11: If select is already low when busy falls, the pins show bit 11 of the newly published results in the cycle busy is seen low.
- R12: Serial clock falling edges while select is high have no effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Conversion start, acts on its falling edge (asynchronous) |
| chan_a_in | input | 12 | Behavioural value for channel A |
| chan_b_in | input | 12 | Behavioural value for channel B |
| sel_n | input | 1 | Active-low read select (asynchronous) |
| sclk | input | 1 | Serial read clock, acts on its falling edges (asynchronous) |
| busy | output | 1 | High while a conversion runs |
| dout_a | output | 1 | Data bit of pin A |
| dout_a_oe | output | 1 | Output enable of pin A |
| dout_b | output | 1 | Data bit of pin B |
| dout_b_oe | output | 1 | Output enable of pin B |

## Verification
The assertions check several properties on every cycle:
- busy rises only after a detected start edge, and it holds while the timer is nonzero;
- a second start edge leaves the countdown untouched;
- the bit counter steps by one or clears, never passes 24, and is zero after a select falling edge or while select is high.

Some behaviour can only be shown by the bench's scenarios, because it depends on the data values:
- the actual bit order on each pin, including the crossover to the other channel;
- the zero tail after 24 edges;
- the sampling instant of the channel inputs;
- the MSB appearing when busy falls under an early select;
- clock edges ignored while select is high.

// File: rtl/adc_sport_pkg.sv
// Shared constants of the dual-channel serial read port.
// Assumes: every module of the block takes its defaults from here.
package adc_sport_pkg;
    localparam int unsigned RES_W       = 12; // bits per channel result
    localparam int unsigned CONV_CYCLES = 20; // conversion length in clk cycles
    localparam int unsigned SYNC_STAGES = 2;  // synchroniser depth
endpackage

// File: rtl/sport_sync.sv
// Multi-bit synchroniser with falling-edge detection.
// Assumes: inputs are asynchronous, idle high, and each bit is independent.
module sport_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = adc_sport_pkg::SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] fell
);
    logic [STAGES-1:0][WIDTH-1:0] stg;
    logic [WIDTH-1:0]             prev;

    // shift raw inputs through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign lvl = stg[STAGES-1];

    // remember last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl;
    end

    assign fell = prev & ~lvl;
endmodule

// File: rtl/conv_ctrl.sv
// Conversion timer: samples both channels on an accepted start edge,
// keeps busy high for CONV_CYCLES cycles, then publishes the samples.
// Assumes: start_fell is a single-cycle pulse in the clk domain.
module conv_ctrl #(
    parameter int unsigned RES_W       = adc_sport_pkg::RES_W,
    parameter int unsigned CONV_CYCLES = adc_sport_pkg::CONV_CYCLES,
    localparam int unsigned CW         = $clog2(CONV_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_fell,
    input  logic [RES_W-1:0] chan_a_in,
    input  logic [RES_W-1:0] chan_b_in,
    output logic             busy,
    output logic [CW-1:0]    conv_left,
    output logic [RES_W-1:0] res_a,
    output logic [RES_W-1:0] res_b
);
    logic [RES_W-1:0] held_a, held_b;

    // accept start when idle, count down, publish on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            conv_left <= '0;
            held_a    <= '0;
            held_b    <= '0;
            res_a     <= '0;
            res_b     <= '0;
        end else if (start_fell && !busy) begin
            busy      <= 1'b1;
            conv_left <= CW'(CONV_CYCLES - 1);
            held_a    <= chan_a_in;
            held_b    <= chan_b_in;
        end else if (busy) begin
            if (conv_left == '0) begin
                busy  <= 1'b0;
                res_a <= held_a;
                res_b <= held_b;
            end else begin
                conv_left <= conv_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_frame.sv
// Select-framed serializer: counts serial clock falling edges inside a frame
// and drives, per pin, its own result then the other channel's result.
// Assumes: cs_lvl and edge pulses are already synchronised to clk.
module serial_frame #(
    parameter int unsigned RES_W = adc_sport_pkg::RES_W,
    localparam int unsigned FRAME = 2 * RES_W,
    localparam int unsigned CW    = $clog2(FRAME + 1),
    localparam int unsigned IW    = (RES_W > 1) ? $clog2(RES_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_lvl,
    input  logic             cs_fell,
    input  logic             sclk_fell,
    input  logic [RES_W-1:0] res_a,
    input  logic [RES_W-1:0] res_b,
    output logic [CW-1:0]    bit_cnt,
    output logic [1:0]       dout,
    output logic [1:0]       oe
);
    logic [CW-1:0] sel;

    // count qualified clock edges within a frame, saturating at FRAME
    always_ff @(posedge clk) begin
        if (!rst_n)                   bit_cnt <= '0;
        else if (cs_lvl || cs_fell)   bit_cnt <= '0;
        else if (sclk_fell && bit_cnt < CW'(FRAME))
                                      bit_cnt <= bit_cnt + 1'b1;
    end

    // bit position inside the current half of the frame
    always_comb begin
        if (bit_cnt < CW'(RES_W)) sel = CW'(RES_W - 1) - bit_cnt;
        else                      sel = CW'(FRAME - 1) - bit_cnt;
    end

    for (genvar g = 0; g < 2; g++) begin : g_pin
        logic [RES_W-1:0] own, oth;
        logic             bitv;
        assign own = (g == 0) ? res_a : res_b;
        assign oth = (g == 0) ? res_b : res_a;

        // pick own result, then the other channel, then zero
        always_comb begin
            if (bit_cnt < CW'(RES_W))      bitv = own[sel[IW-1:0]];
            else if (bit_cnt < CW'(FRAME)) bitv = oth[sel[IW-1:0]];
            else                           bitv = 1'b0;
        end

        assign oe[g]   = ~cs_lvl;
        assign dout[g] = ~cs_lvl & bitv;
    end
endmodule

// File: rtl/dual_adc_sport.sv
// Top of the dual-channel serial read port: synchroniser, conversion timer
// and serializer. Assumes asynchronous start, select and serial clock inputs.
module dual_adc_sport #(
    parameter int unsigned RES_W       = adc_sport_pkg::RES_W,
    parameter int unsigned CONV_CYCLES = adc_sport_pkg::CONV_CYCLES,
    localparam int unsigned CCW        = $clog2(CONV_CYCLES + 1),
    localparam int unsigned BCW        = $clog2(2 * RES_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_n,
    input  logic [RES_W-1:0] chan_a_in,
    input  logic [RES_W-1:0] chan_b_in,
    input  logic             sel_n,
    input  logic             sclk,
    output logic             busy,
    output logic             dout_a,
    output logic             dout_a_oe,
    output logic             dout_b,
    output logic             dout_b_oe
);
    logic [2:0]       s_lvl, s_fell;
    logic             start_fell, cs_lvl, cs_fell, sclk_fell;
    logic [CCW-1:0]   conv_left;
    logic [BCW-1:0]   bit_cnt;
    logic [RES_W-1:0] res_a, res_b;
    logic [1:0]       dout, oe;

    sport_sync #(.WIDTH(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sclk, sel_n, start_n}),
        .lvl(s_lvl), .fell(s_fell)
    );

    assign start_fell = s_fell[0];
    assign cs_lvl     = s_lvl[1];
    assign cs_fell    = s_fell[1];
    assign sclk_fell  = s_fell[2];

    conv_ctrl #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk(clk), .rst_n(rst_n), .start_fell(start_fell),
        .chan_a_in(chan_a_in), .chan_b_in(chan_b_in),
        .busy(busy), .conv_left(conv_left), .res_a(res_a), .res_b(res_b)
    );

    serial_frame #(.RES_W(RES_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_fell(cs_fell),
        .sclk_fell(sclk_fell), .res_a(res_a), .res_b(res_b),
        .bit_cnt(bit_cnt), .dout(dout), .oe(oe)
    );

    assign dout_a    = dout[0];
    assign dout_b    = dout[1];
    assign dout_a_oe = oe[0];
    assign dout_b_oe = oe[1];
endmodule

// File: rtl/dual_adc_sport_chk.sv
// Checker for dual_adc_sport: timer and frame-counter properties.
// Assumes: bound to the top so that it sees its internal nets.
module dual_adc_sport_chk #(
    parameter int unsigned CCW   = 5,
    parameter int unsigned BCW   = 5,
    parameter int unsigned FRAME = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           start_fell,
    input logic [CCW-1:0] conv_left,
    input logic           cs_lvl,
    input logic           cs_fell,
    input logic [BCW-1:0] bit_cnt
);
    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_fell));
    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_left != '0) |=> busy);
    // R3
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_fell && conv_left != '0) |=> (conv_left == $past(conv_left) - 1'b1));
    // R8
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BCW'(FRAME));
    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt != $past(bit_cnt)) |-> (bit_cnt == $past(bit_cnt) + 1'b1 || bit_cnt == '0));
    // R9
    cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> bit_cnt == '0);
    // R10
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fell |=> bit_cnt == '0);
endmodule

bind dual_adc_sport dual_adc_sport_chk #(.CCW(CCW), .BCW(BCW), .FRAME(2 * RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start_fell(start_fell),
    .conv_left(conv_left), .cs_lvl(cs_lvl), .cs_fell(cs_fell), .bit_cnt(bit_cnt)
);

// File: tb/sim_dual_adc_sport.sv
module sim_dual_adc_sport;
    localparam int CONV = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_n = 1'b1, sel_n = 1'b1, sclk = 1'b1;
    logic [11:0] chan_a_in = '0, chan_b_in = '0;
    logic busy, dout_a, dout_a_oe, dout_b, dout_b_oe;

    int checks = 0, fails = 0, idx = 0;
    logic [11:0] cur_a = '0, cur_b = '0;
    bit done = 0;

    always #4 clk = ~clk;

    dual_adc_sport #(.RES_W(12), .CONV_CYCLES(CONV)) u0 (
        .clk(clk), .rst_n(rst_n), .start_n(start_n),
        .chan_a_in(chan_a_in), .chan_b_in(chan_b_in),
        .sel_n(sel_n), .sclk(sclk), .busy(busy),
        .dout_a(dout_a), .dout_a_oe(dout_a_oe),
        .dout_b(dout_b), .dout_b_oe(dout_b_oe)
    );

    function automatic logic expb(logic [11:0] own, logic [11:0] oth, int k);
        if (k < 12)      return own[11-k];
        else if (k < 24) return oth[23-k];
        else             return 1'b0;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_pins(string tag);
        check(dout_a == expb(cur_a, cur_b, idx), tag, dout_a, expb(cur_a, cur_b, idx));
        check(dout_b == expb(cur_b, cur_a, idx), tag, dout_b, expb(cur_b, cur_a, idx));
    endtask

    // run one conversion; retrig adds a second start edge during busy (R3)
    task automatic convert(logic [11:0] a, logic [11:0] b, bit retrig, bit sel_low);
        int n = 0;
        chan_a_in = a; chan_b_in = b;
        start_n = 1'b0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (c == 4) begin
                start_n = 1'b1;
                chan_a_in = ~a; chan_b_in = ~b; // R4: late change must not matter
            end
            if (retrig && c == 8)  start_n = 1'b0;
            if (retrig && c == 12) start_n = 1'b1;
            if (busy) n++;
            if (n > 0 && !busy) break;
        end
        cur_a = a; cur_b = b;
        check(n == CONV, retrig ? "R3 busy length with retrigger" : "R2 busy length", n, CONV);
        if (sel_low) begin
            idx = 0;
            check_pins("R11 MSB at busy fall");
        end
    endtask

    task automatic frame_open(bit coincide);
        idx = 0;
        sel_n = 1'b0;
        if (coincide) sclk = 1'b0;
        wait_n(6);
        check(dout_a_oe && dout_b_oe, "R5 enables", {dout_a_oe, dout_b_oe}, 3);
        check_pins(coincide ? "R10 coincident edge ignored" : "R5 MSB first");
        if (coincide) begin sclk = 1'b1; wait_n(8); end
    endtask

    task automatic pulse(bit do_check);
        sclk = 1'b0;
        wait_n(6);
        if (idx < 24) idx++;
        if (do_check) begin
            if (idx < 12)       check_pins("R6 own bits");
            else if (idx < 24)  check_pins("R7 other channel");
            else                check_pins("R8 zero tail");
        end
        wait_n(2);
        sclk = 1'b1;
        wait_n(8);
    endtask

    task automatic frame_close();
        sel_n = 1'b1;
        wait_n(6);
        check(!dout_a_oe && !dout_b_oe && !dout_a && !dout_b, "R9 released",
              {dout_a_oe, dout_b_oe, dout_a, dout_b}, 0);
        idx = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        // R1 reset state
        check(!busy && !dout_a_oe && !dout_b_oe && !dout_a && !dout_b, "R1 reset outputs",
              {busy, dout_a_oe, dout_b_oe, dout_a, dout_b}, 0);
        frame_open(1'b0);            // R1: zero results read out
        check(dout_a == 1'b0 && dout_b == 1'b0, "R1 zero result", {dout_a, dout_b}, 0);
        frame_close();

        // directed: full chained read on both pins
        convert(12'hA5C, 12'h3E1, 1'b0, 1'b0);
        frame_open(1'b0);
        for (int i = 0; i < 27; i++) pulse(1'b1);
        frame_close();

        // R3 retrigger during busy
        convert(12'h801, 12'hFFE, 1'b1, 1'b0);

        // R12 clock edges with select high, then a fresh frame
        for (int i = 0; i < 5; i++) begin
            pulse(1'b0);
            check(!dout_a_oe && !dout_a, "R12 idle pins", {dout_a_oe, dout_a}, 0);
        end
        idx = 0;
        frame_open(1'b0);
        pulse(1'b1);
        frame_close();

        // R10 coincident edges
        frame_open(1'b1);
        for (int i = 0; i < 13; i++) pulse(1'b1);
        frame_close();

        // R11 select low before busy falls
        sel_n = 1'b0;
        wait_n(6);
        convert(12'h9C3, 12'h46B, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) pulse(1'b1);
        frame_close();

        // constrained random frames
        for (int t = 0; t < 15; t++) begin
            convert(12'($urandom), 12'($urandom), 1'($urandom_range(0, 1)), 1'b0);
            frame_open(1'($urandom_range(0, 1)));
            for (int i = 0, n = $urandom_range(0, 28); i < n; i++) pulse(1'b1);
            frame_close();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule